// File: doc/BRIEF.md
# Two-Wire Bus Slave Receiver with Event Status Codes

This block is the receive half of a two-wire (I2C) slave. It watches the synchronised clock and data lines, recognises START, repeated START and STOP, and collects the 7-bit address that follows each START. It answers to a programmable own address and, when enabled, to the general call address 00h. A match only counts when the direction bit is 0 (write), the block is enabled, and acknowledge-enable is set. The block then acknowledges the address and the data bytes that follow.

Each significant event raises an interrupt flag and posts an 8-bit status code. After an address or data byte the block also holds the clock line low. Software reads the status and, for a data byte, the received byte. It then pulses a clear input, and the bus transfer resumes. Clearing acknowledge-enable makes the block answer the next data byte with NACK. While the bit stays clear, the block does not react to its own address, so it is isolated from the bus. An input from the master logic marks an address match that follows lost arbitration, and that match gets its own status codes.

Top module: `i2c_slv_rx`

## Requirements
- R1: After reset the flag is 0, the status reads F8h, the data register reads 00h, and neither bus line is pulled low.
- R2: An address byte whose bits 7:1 equal the own-address register bits 7:1 and whose bit 0 is 0 is acknowledged (SDA low during the ninth clock). The flag is then set with status 60h.
- R3: Address 00h with direction 0 is acknowledged with status 70h when own-address register bit 0 (general-call enable) is 1. It is ignored (no ACK, no flag) when that bit is 0.
- R4: An address with direction bit 1, or one that matches neither the own address nor an enabled general call, gets no ACK, no flag and no status change.
- R5: A data byte received after an acknowledged address is stored in the data register and acknowledged. The status is 80h after an own-address match and 90h after a general call.
- R6: If acknowledge-enable is cleared after the address, the next data byte is stored and answered with NACK, with status 88h (98h after a general call). Later bytes are ignored until the next START.
- R7: While the flag is set after an address or data byte, SCL is held low. A clear pulse drops the flag, releases SCL and returns the status to F8h.
- R8: While acknowledge-enable is 0 the own address is not acknowledged. Once it is set again, the next addressing is recognised.
- R9: A STOP or repeated START while addressed sets the flag with status A0h and does not hold SCL. After a repeated START, a new address is received normally.
- R10: When the arbitration-lost input is 1 at an address match, the status is 68h for the own address and 78h for a general call.
- R11: With the enable bit 0 the block acknowledges nothing and releases SDA within one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_low_o | output | 1 | Pull SCL low (clock stretch) |
| sda_low_o | output | 1 | Pull SDA low (acknowledge) |
| own_we_i | input | 1 | Write strobe for own-address register |
| own_wdata_i | input | 8 | Bits 7:1 own address, bit 0 general-call enable |
| ctl_we_i | input | 1 | Write strobe for control register |
| ctl_wdata_i | input | 2 | Bit 0 acknowledge-enable, bit 1 block enable |
| flag_clr_i | input | 1 | Pulse to clear the flag and continue |
| arb_lost_i | input | 1 | Master logic lost arbitration |
| irq_o | output | 1 | Interrupt flag |
| status_o | output | 8 | Status code |
| data_o | output | 8 | Last received data byte |

## Verification
On every cycle the assertions check three things. The flag and a non-idle status always agree. SCL is held only while the flag is set, and a clear releases it. SDA is pulled low only while acknowledge-enable was set and never once the block is disabled. The bench's bus scenarios are the only evidence for the rest. These include which address patterns get an ACK, the exact status code for each event, the byte captured in the data register, and the switch to NACK and then silence after acknowledge-enable is dropped. They also include A0h on STOP and repeated START, and the codes for a match after lost arbitration.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_ADDR_ACK, PH_DATA, PH_DATA_ACK, PH_SKIP
  } phase_t;

  localparam logic [7:0] ST_OWN_W    = 8'h60;
  localparam logic [7:0] ST_ARB_OWN  = 8'h68;
  localparam logic [7:0] ST_GC_W     = 8'h70;
  localparam logic [7:0] ST_ARB_GC   = 8'h78;
  localparam logic [7:0] ST_OWN_ACK  = 8'h80;
  localparam logic [7:0] ST_OWN_NACK = 8'h88;
  localparam logic [7:0] ST_GC_ACK   = 8'h90;
  localparam logic [7:0] ST_GC_NACK  = 8'h98;
  localparam logic [7:0] ST_END      = 8'hA0;
  localparam logic [7:0] ST_IDLE     = 8'hF8;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LINES = 2;
  logic [LINES-1:0] raw, synced, prev_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '1;
      else     chain_q <= {chain_q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= synced;
  end

  assign sda_o      = synced[1];
  assign scl_rise_o = synced[0] & ~prev_q[0];
  assign scl_fall_o = ~synced[0] & prev_q[0];
  assign start_o    = synced[0] & prev_q[0] & prev_q[1] & ~synced[1];
  assign stop_o     = synced[0] & prev_q[0] & ~prev_q[1] & synced[1];
endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine
  import i2c_slv_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-2:0] own_addr_i,
  input  logic              gc_en_i,
  input  logic              ack_en_i,
  input  logic              en_i,
  input  logic              arb_lost_i,
  output logic              evt_vld_o,
  output logic [7:0]        evt_code_o,
  output logic              evt_hold_o,
  output logic              load_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              sda_low_o
);
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [CNT_W:0] FULL = (CNT_W+1)'(BYTE_W);

  phase_t             phase_q;
  logic [BYTE_W-1:0]  shift_q;
  logic [CNT_W:0]     cnt_q;
  logic               gc_q, ack_q;
  logic               addressed, byte_done, hit_own, hit_gc, may_ack;

  assign addressed = (phase_q == PH_DATA) || (phase_q == PH_DATA_ACK);
  assign byte_done = (cnt_q == FULL);
  assign may_ack   = en_i && ack_en_i && !shift_q[0];
  assign hit_own   = may_ack && (shift_q[BYTE_W-1:1] == own_addr_i);
  assign hit_gc    = may_ack && gc_en_i && (shift_q[BYTE_W-1:1] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      shift_q    <= '0;
      cnt_q      <= '0;
      gc_q       <= 1'b0;
      ack_q      <= 1'b0;
      sda_low_o  <= 1'b0;
      evt_vld_o  <= 1'b0;
      evt_code_o <= ST_IDLE;
      evt_hold_o <= 1'b0;
      load_o     <= 1'b0;
      byte_o     <= '0;
    end else begin
      evt_vld_o <= 1'b0;
      load_o    <= 1'b0;
      if (start_i || stop_i) begin
        if (addressed) begin
          evt_vld_o  <= 1'b1;
          evt_code_o <= ST_END;
          evt_hold_o <= 1'b0;
        end
        phase_q   <= start_i ? PH_ADDR : PH_IDLE;
        cnt_q     <= '0;
        sda_low_o <= 1'b0;
      end else if (scl_rise_i) begin
        if ((phase_q == PH_ADDR || phase_q == PH_DATA) && !byte_done) begin
          shift_q <= {shift_q[BYTE_W-2:0], sda_i};
          cnt_q   <= cnt_q + (CNT_W+1)'(1);
        end
      end else if (scl_fall_i) begin
        case (phase_q)
          PH_ADDR: if (byte_done) begin
            if (hit_own || hit_gc) begin
              sda_low_o <= 1'b1;
              gc_q      <= !hit_own;
              phase_q   <= PH_ADDR_ACK;
            end else begin
              phase_q   <= PH_SKIP;
            end
          end
          PH_ADDR_ACK: begin
            sda_low_o  <= 1'b0;
            cnt_q      <= '0;
            phase_q    <= PH_DATA;
            evt_vld_o  <= 1'b1;
            evt_hold_o <= 1'b1;
            if (gc_q) evt_code_o <= arb_lost_i ? ST_ARB_GC : ST_GC_W;
            else      evt_code_o <= arb_lost_i ? ST_ARB_OWN : ST_OWN_W;
          end
          PH_DATA: if (byte_done) begin
            load_o    <= 1'b1;
            byte_o    <= shift_q;
            ack_q     <= ack_en_i;
            sda_low_o <= ack_en_i;
            phase_q   <= PH_DATA_ACK;
          end
          PH_DATA_ACK: begin
            sda_low_o  <= 1'b0;
            cnt_q      <= '0;
            phase_q    <= ack_q ? PH_DATA : PH_SKIP;
            evt_vld_o  <= 1'b1;
            evt_hold_o <= 1'b1;
            if (gc_q) evt_code_o <= ack_q ? ST_GC_ACK : ST_GC_NACK;
            else      evt_code_o <= ack_q ? ST_OWN_ACK : ST_OWN_NACK;
          end
          default: ;
        endcase
      end
      if (!en_i) begin
        phase_q   <= PH_IDLE;
        sda_low_o <= 1'b0;
      end
    end
  end

  AST_SDA_OFF_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !sda_low_o); // R11
  AST_ACK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low_o) |-> $past(ack_en_i)); // R8
endmodule

// File: rtl/i2c_slv_rx.sv
module i2c_slv_rx
  import i2c_slv_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  input  logic              own_we_i,
  input  logic [BYTE_W-1:0] own_wdata_i,
  input  logic              ctl_we_i,
  input  logic [1:0]        ctl_wdata_i,
  input  logic              flag_clr_i,
  input  logic              arb_lost_i,
  output logic              irq_o,
  output logic [7:0]        status_o,
  output logic [BYTE_W-1:0] data_o
);
  logic [BYTE_W-1:0] own_q;
  logic              ack_en_q, en_q, flag_q, hold_q;
  logic [7:0]        status_q;
  logic [BYTE_W-1:0] data_q, rx_byte;
  logic              sda_s, scl_rise, scl_fall, start_s, stop_s;
  logic              evt_vld, evt_hold, rx_load;
  logic [7:0]        evt_code;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_s), .stop_o(stop_s)
  );

  i2c_rx_engine #(.BYTE_W(BYTE_W)) u_engine (
    .clk(clk), .rst(rst), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_i(sda_s), .start_i(start_s), .stop_i(stop_s),
    .own_addr_i(own_q[BYTE_W-1:1]), .gc_en_i(own_q[0]),
    .ack_en_i(ack_en_q), .en_i(en_q), .arb_lost_i(arb_lost_i),
    .evt_vld_o(evt_vld), .evt_code_o(evt_code), .evt_hold_o(evt_hold),
    .load_o(rx_load), .byte_o(rx_byte), .sda_low_o(sda_low_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q    <= '0;
      ack_en_q <= 1'b0;
      en_q     <= 1'b0;
      flag_q   <= 1'b0;
      hold_q   <= 1'b0;
      status_q <= ST_IDLE;
      data_q   <= '0;
    end else begin
      if (own_we_i) own_q <= own_wdata_i;
      if (ctl_we_i) begin
        ack_en_q <= ctl_wdata_i[0];
        en_q     <= ctl_wdata_i[1];
      end
      if (flag_clr_i) begin
        flag_q   <= 1'b0;
        hold_q   <= 1'b0;
        status_q <= ST_IDLE;
      end
      if (evt_vld) begin
        flag_q   <= 1'b1;
        hold_q   <= evt_hold;
        status_q <= evt_code;
      end
      if (rx_load) data_q <= rx_byte;
    end
  end

  assign scl_low_o = hold_q;
  assign irq_o     = flag_q;
  assign status_o  = status_q;
  assign data_o    = data_q;

  AST_FLAG_STATUS: assert property (@(posedge clk) disable iff (rst)
    irq_o == (status_o != ST_IDLE)); // R7
  AST_HOLD_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    scl_low_o |-> irq_o); // R7
  AST_CLR_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (flag_clr_i && scl_low_o) |=> !scl_low_o); // R7
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    status_o == ST_IDLE || status_o == ST_OWN_W || status_o == ST_ARB_OWN ||
    status_o == ST_GC_W || status_o == ST_ARB_GC || status_o == ST_OWN_ACK ||
    status_o == ST_OWN_NACK || status_o == ST_GC_ACK || status_o == ST_GC_NACK ||
    status_o == ST_END); // R2
endmodule

// File: tb/test_i2c_slv_rx.sv
module test_i2c_slv_rx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_low_o, sda_low_o, irq_o;
  logic own_we = 1'b0, ctl_we = 1'b0, flag_clr = 1'b0, arb_lost = 1'b0;
  logic [7:0] own_wdata = 8'h00;
  logic [1:0] ctl_wdata = 2'b00;
  logic [7:0] status_o, data_o;
  logic scl_bus, sda_bus;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign scl_bus = !(m_scl_low || scl_low_o);
  assign sda_bus = !(m_sda_low || sda_low_o);

  i2c_slv_rx i_i2c_slv_rx (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
    .own_we_i(own_we), .own_wdata_i(own_wdata),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .flag_clr_i(flag_clr), .arb_lost_i(arb_lost),
    .irq_o(irq_o), .status_o(status_o), .data_o(data_o)
  );

  // {own reg, address byte, data byte, expect ack, status after address, status after data}
  localparam int NV = 6;
  localparam logic [40:0] VEC [NV] = '{
    {8'h54, 8'h54, 8'hA5, 1'b1, 8'h60, 8'h80},  // R2 R5 own write
    {8'h55, 8'h00, 8'h3C, 1'b1, 8'h70, 8'h90},  // R3 R5 general call enabled
    {8'h54, 8'h00, 8'h00, 1'b0, 8'hF8, 8'hF8},  // R3 general call disabled
    {8'h54, 8'h55, 8'h00, 1'b0, 8'hF8, 8'hF8},  // R4 read direction
    {8'h54, 8'h56, 8'h00, 1'b0, 8'hF8, 8'hF8},  // R4 other address
    {8'hFE, 8'hFE, 8'h00, 1'b1, 8'h60, 8'h80}   // R2 R5 top address, zero data
  };

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R1 watchdog actual=%0d expected<150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask
  task automatic wait_scl(); while (!scl_bus) @(negedge clk); endtask

  task automatic set_own(input logic [7:0] v);
    @(negedge clk) begin own_we = 1; own_wdata = v; end
    @(negedge clk) own_we = 0;
  endtask
  task automatic set_ctl(input logic [1:0] v);
    @(negedge clk) begin ctl_we = 1; ctl_wdata = v; end
    @(negedge clk) ctl_we = 0;
  endtask
  task automatic clr();
    @(negedge clk) flag_clr = 1;
    @(negedge clk) flag_clr = 0;
    w(3);
  endtask

  task automatic m_start();
    m_sda_low = 0; w(5); m_scl_low = 0; wait_scl(); w(10);
    m_sda_low = 1; w(10); m_scl_low = 1; w(10);
  endtask
  task automatic m_stop();
    m_sda_low = 1; w(5); m_scl_low = 0; wait_scl(); w(10);
    m_sda_low = 0; w(20);
  endtask
  task automatic m_bit(input logic b);
    m_sda_low = !b; w(5); m_scl_low = 0; wait_scl(); w(10);
    m_scl_low = 1; w(5);
  endtask
  task automatic m_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) m_bit(b[i]);
    m_sda_low = 0; w(5); m_scl_low = 0; wait_scl(); w(5);
    acked = !sda_bus; w(5); m_scl_low = 1; w(12);
  endtask

  initial begin
    logic a;
    w(4);
    rst = 0;
    w(2);
    // R1 reset state
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    chk("R1 status", status_o, 8'hF8);
    chk("R1 data", data_o, 8'h00);
    chk("R1 lines", {6'd0, scl_low_o, sda_low_o}, 8'h00);

    set_ctl(2'b11);
    for (int v = 0; v < NV; v++) begin
      logic [7:0] own, adr, dat, st1, st2;
      logic ack;
      {own, adr, dat, ack, st1, st2} = VEC[v];
      set_own(own);
      m_start();
      m_byte(adr, a);
      if (ack) begin
        chk(st1 == 8'h70 ? "R3 ack" : "R2 ack", {7'd0, a}, 8'h01);
        chk(st1 == 8'h70 ? "R3 status" : "R2 status", status_o, st1);
        chk("R7 stretch", {6'd0, irq_o, scl_low_o}, 8'h03);
        w(30);
        chk("R7 scl held", {7'd0, scl_bus}, 8'h00);
        clr();
        chk("R7 cleared", {6'd0, irq_o, scl_low_o}, 8'h00);
        chk("R7 idle status", status_o, 8'hF8);
        m_byte(dat, a);
        chk("R5 ack", {7'd0, a}, 8'h01);
        chk("R5 status", status_o, st2);
        chk("R5 data", data_o, dat);
        clr();
        m_stop();
        chk("R9 stop status", status_o, 8'hA0);
        chk("R9 no hold", {6'd0, irq_o, scl_low_o}, 8'h02);
        clr();
      end else begin
        chk("R4 no ack", {7'd0, a}, 8'h00);
        chk("R4 no flag", {7'd0, irq_o}, 8'h00);
        chk("R4 status", status_o, 8'hF8);
        m_stop();
        chk("R4 stop ignored", {7'd0, irq_o}, 8'h00);
      end
    end

    // R6 drop acknowledge-enable mid transfer
    set_own(8'h54);
    m_start(); m_byte(8'h54, a); clr();
    set_ctl(2'b10);
    m_byte(8'h11, a);
    chk("R6 nack", {7'd0, a}, 8'h00);
    chk("R6 status", status_o, 8'h88);
    chk("R6 data", data_o, 8'h11);
    clr();
    m_byte(8'h22, a);
    chk("R6 later byte ignored", {6'd0, a, irq_o}, 8'h00);
    chk("R6 data kept", data_o, 8'h11);
    m_stop();
    chk("R6 stop not addressed", {7'd0, irq_o}, 8'h00);

    // R8 isolation, then resume
    m_start(); m_byte(8'h54, a);
    chk("R8 isolated", {6'd0, a, irq_o}, 8'h00);
    m_stop();
    set_ctl(2'b11);
    m_start(); m_byte(8'h54, a);
    chk("R8 resumed", {6'd0, a, irq_o}, 8'h03);
    chk("R8 status", status_o, 8'h60);
    clr(); m_stop(); clr();

    // R9 repeated start while addressed
    m_start(); m_byte(8'h54, a); clr();
    m_byte(8'h77, a); clr();
    m_start();
    chk("R9 rstart status", status_o, 8'hA0);
    chk("R9 rstart no hold", {6'd0, irq_o, scl_low_o}, 8'h02);
    clr();
    m_byte(8'h54, a);
    chk("R9 readdressed", {7'd0, a}, 8'h01);
    chk("R9 readdressed status", status_o, 8'h60);
    clr(); m_stop(); clr();

    // R10 arbitration lost
    arb_lost = 1;
    set_own(8'h55);
    m_start(); m_byte(8'h54, a);
    chk("R10 own", status_o, 8'h68);
    clr(); m_stop(); clr();
    m_start(); m_byte(8'h00, a);
    chk("R10 gc", status_o, 8'h78);
    clr(); m_stop(); clr();
    arb_lost = 0;

    // R11 block disabled
    set_ctl(2'b01);
    m_start(); m_byte(8'h54, a);
    chk("R11 disabled", {5'd0, a, irq_o, sda_low_o}, 8'h00);
    m_stop();

    done = 1;
    summary();
    $finish;
  end
endmodule